// File: doc/BRIEF.md
# Dual-Input Non-Retriggerable One-Shot

This block turns a qualified input transition into a single high pulse of programmable length on `pulse_o`. `pulse_n_o` always carries its complement. Three things can start a pulse:

- a falling edge on the active-low trigger `trig_fall_n_i`;
- a rising edge on the active-high trigger `trig_rise_i`;
- the release (rising edge) of the active-low `clear_n_i`.

Each trigger input is only honoured while the other sits at its enabling level, so either one can serve as a gate for the other. Once a pulse is running, further trigger activity is ignored until the pulse times out.

A low level on `clear_n_i` takes the output low and blocks every trigger while it stays low, so a pulse can be cut short. All three control inputs may be asynchronous to `clk_i`. Each passes through a synchroniser of `SYNC_STAGES` flops before edge detection, which gives a trigger-to-output latency of `SYNC_STAGES + 1` clock cycles. That latency does not depend on the programmed width.

`width_i` is sampled in the cycle the pulse starts. It is expected to be quasi-static, driven from the `clk_i` domain. The asynchronous reset `arst_n_i` asserts at once and is released through a local reset synchroniser.

Top module: `mono_pulse_gen`

## Requirements
- R1: While `arst_n_i` is low, and after its release with the trigger inputs at their idle levels (trig_fall_n_i=1, trig_rise_i=0, clear_n_i=1), pulse_o is 0 and pulse_n_o is 1.
- R2: A falling edge on trig_fall_n_i while trig_rise_i=1 and clear_n_i=1 starts a pulse. pulse_o is first seen high on the SYNC_STAGES+1-th rising clock edge after the input change, whatever the width.
- R3: A rising edge on trig_rise_i while trig_fall_n_i=0 and clear_n_i=1 starts a pulse with the same latency.
- R4: A rising edge on clear_n_i while trig_fall_n_i=0 and trig_rise_i=1 starts a pulse with the same latency.
- R5: A falling edge on trig_fall_n_i while trig_rise_i=0, or a rising edge on trig_rise_i while trig_fall_n_i=1, leaves pulse_o low.
- R6: A pulse stays high for exactly the number of clock cycles given by width_i as sampled at its start. Later changes to width_i do not alter the running pulse. The maximum value (all ones) is honoured.
- R7: A width_i of zero produces a pulse of one clock cycle.
- R8: Qualified trigger edges during a running pulse neither lengthen it nor start a new pulse after it ends.
- R9: Taking clear_n_i low during a pulse drives pulse_o low SYNC_STAGES+1 cycles later, shorter than the programmed width.
- R10: While clear_n_i is low, trigger edges on trig_fall_n_i and trig_rise_i have no effect and pulse_o stays low.
- R11: If the release of clear_n_i and a qualified trig_rise_i edge reach the edge detector in the same cycle, exactly one pulse is produced.
- R12: pulse_n_o is the complement of pulse_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_fall_n_i | input | 1 | Falling-edge trigger, low level enables the rising trigger |
| trig_rise_i | input | 1 | Rising-edge trigger, high level enables the falling trigger |
| clear_n_i | input | 1 | Active-low clear; its release can also trigger |
| width_i | input | WIDTH_BITS | Pulse length in clock cycles (0 treated as 1) |
| pulse_o | output | 1 | One-shot output, high during a pulse |
| pulse_n_o | output | 1 | Complement of pulse_o |

## Verification
The bench builds the block with SYNC_STAGES = 2 and WIDTH_BITS = 6. The short synchroniser keeps the three-cycle trigger latency and the clear truncation point easy to predict cycle by cycle. The six-bit width lets the bench reach the all-ones maximum of 63 cycles, as well as the zero and one-cycle corners, within a short run. A behavioural reference model delays each input by the synchroniser depth and is compared against both outputs on every clock. Directed sequences cover gating by the opposite trigger, clear hold-off and truncation, retrigger attempts, and a coincident clear release with a trigger edge.

// File: rtl/mono_pkg.sv
package mono_pkg;
  localparam int TRIG_N   = 3;
  localparam int IDX_FALL = 0;
  localparam int IDX_RISE = 1;
  localparam int IDX_CLR  = 2;

  typedef logic [TRIG_N-1:0] trig_vec_t;

  // Idle levels: clear released, rising trigger low, falling trigger high.
  localparam trig_vec_t TRIG_IDLE = 3'b101;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PULSE = 1'b1
  } pulse_state_e;
endpackage

// File: rtl/mono_rst_sync.sv
module mono_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mono_sync.sv
module mono_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] d;
    if (g == 0) begin : g_first
      assign d = din_i;
    end else begin : g_next
      assign d = g_stage[g-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        q <= RST_VAL;
      end else begin
        q <= d;
      end
    end
  end

  assign dout_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/mono_trigger.sv
module mono_trigger
  import mono_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  trig_vec_t sync_i,
  output logic      fire_o,
  output logic      clr_lvl_o
);
  trig_vec_t prev_q;
  trig_vec_t prev_d;
  logic fall_edge, rise_edge, clr_release;
  logic fall_lvl_low, rise_lvl_high, clr_lvl_high;

  always_comb begin
    prev_d        = sync_i;
    fall_lvl_low  = ~sync_i[IDX_FALL];
    rise_lvl_high = sync_i[IDX_RISE];
    clr_lvl_high  = sync_i[IDX_CLR];
    fall_edge     = prev_q[IDX_FALL] & ~sync_i[IDX_FALL];
    rise_edge     = ~prev_q[IDX_RISE] & sync_i[IDX_RISE];
    clr_release   = ~prev_q[IDX_CLR] & sync_i[IDX_CLR];
    fire_o        = clr_lvl_high &
                    ((fall_edge & rise_lvl_high) |
                     (rise_edge & fall_lvl_low) |
                     (clr_release & fall_lvl_low & rise_lvl_high));
    clr_lvl_o     = clr_lvl_high;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prev_q <= TRIG_IDLE;
    end else begin
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/mono_timer.sv
module mono_timer
  import mono_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  fire_i,
  input  logic                  clr_lvl_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic                  pulse_o
);
  localparam logic [WIDTH_BITS-1:0] ONE = WIDTH_BITS'(1);

  pulse_state_e          state_q, state_d;
  logic [WIDTH_BITS-1:0] cnt_q, cnt_d;
  logic [WIDTH_BITS-1:0] width_eff;
  logic                  upd_en;

  always_comb begin
    width_eff = (width_i == '0) ? ONE : width_i;
    upd_en    = (state_q == ST_PULSE) | fire_i;
    state_d   = state_q;
    cnt_d     = cnt_q;
    if (!clr_lvl_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fire_i) begin
            state_d = ST_PULSE;
            cnt_d   = width_eff;
          end
        end
        ST_PULSE: begin
          if (cnt_q <= ONE) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_o = (state_q == ST_PULSE);
endmodule

// File: rtl/mono_pulse_gen.sv
module mono_pulse_gen
  import mono_pkg::*;
#(
  parameter int WIDTH_BITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  arst_n_i,
  input  logic                  trig_fall_n_i,
  input  logic                  trig_rise_i,
  input  logic                  clear_n_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic                  pulse_o,
  output logic                  pulse_n_o
);
  logic      rst_core_n;
  trig_vec_t raw_vec;
  trig_vec_t sync_vec;
  logic      fire;
  logic      clr_sync;
  logic      pulse;

  always_comb begin
    raw_vec           = TRIG_IDLE;
    raw_vec[IDX_FALL] = trig_fall_n_i;
    raw_vec[IDX_RISE] = trig_rise_i;
    raw_vec[IDX_CLR]  = clear_n_i;
  end

  mono_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_o  (rst_core_n)
  );

  mono_sync #(
    .STAGES  (SYNC_STAGES),
    .W       (TRIG_N),
    .RST_VAL (TRIG_IDLE)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_core_n),
    .din_i   (raw_vec),
    .dout_o  (sync_vec)
  );

  mono_trigger u_trigger (
    .clk_i     (clk_i),
    .rst_n_i   (rst_core_n),
    .sync_i    (sync_vec),
    .fire_o    (fire),
    .clr_lvl_o (clr_sync)
  );

  mono_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
    .clk_i     (clk_i),
    .rst_n_i   (rst_core_n),
    .fire_i    (fire),
    .clr_lvl_i (clr_sync),
    .width_i   (width_i),
    .pulse_o   (pulse)
  );

  assign pulse_o   = pulse;
  assign pulse_n_o = ~pulse;
endmodule

// File: rtl/mono_pulse_gen_chk.sv
module mono_pulse_gen_chk #(
  parameter int WIDTH_BITS = 8
) (
  input logic                  clk_i,
  input logic                  rst_n_i,
  input logic [WIDTH_BITS-1:0] width_i,
  input logic                  pulse_o,
  input logic                  pulse_n_o,
  input logic                  clr_sync_i,
  input logic                  fire_i
);
  logic [WIDTH_BITS:0] hi_cnt;
  logic [WIDTH_BITS:0] wlim;

  // Tracks the length of the running pulse and the width latched at its start.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hi_cnt <= '0;
      wlim   <= (WIDTH_BITS+1)'(1);
    end else if (!pulse_o) begin
      hi_cnt <= '0;
      wlim   <= (width_i == '0) ? (WIDTH_BITS+1)'(1) : {1'b0, width_i};
    end else begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r12_complement: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pulse_n_o == ~pulse_o);

  a_r6_width_max: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pulse_o |-> (hi_cnt < wlim));

  a_r6_width_exact: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($fell(pulse_o) && $past(clr_sync_i)) |-> ($past(hi_cnt) + 1'b1 == $past(wlim)));

  a_r9_clear_ends: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !clr_sync_i |=> !pulse_o);

  a_r8_rise_needs_fire: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(pulse_o) |-> $past(fire_i));
endmodule

bind mono_pulse_gen mono_pulse_gen_chk #(.WIDTH_BITS(WIDTH_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_core_n),
  .width_i    (width_i),
  .pulse_o    (pulse_o),
  .pulse_n_o  (pulse_n_o),
  .clr_sync_i (clr_sync),
  .fire_i     (fire)
);

// File: tb/tb_mono_pulse_gen.sv
`timescale 1ns/1ps
module tb_mono_pulse_gen;
  localparam int    WB   = 6;
  localparam int    SS   = 2;
  localparam int    LAT  = SS + 1;
  localparam real   HALF = 2.5;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          fall_n, rise, clr_n;
  logic [WB-1:0] width;
  logic          pulse, pulse_n;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    mon_en   = 1'b0;
  string cur_req  = "R1";

  always #(HALF) clk = ~clk;

  mono_pulse_gen #(.WIDTH_BITS(WB), .SYNC_STAGES(SS)) dut (
    .clk_i         (clk),
    .arst_n_i      (arst_n),
    .trig_fall_n_i (fall_n),
    .trig_rise_i   (rise),
    .clear_n_i     (clr_n),
    .width_i       (width),
    .pulse_o       (pulse),
    .pulse_n_o     (pulse_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: inputs seen SS edges late, edge = change of that view.
  int ha[SS+1];
  int hb[SS+1];
  int hc[SS+1];
  bit m_q;
  int m_cnt;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i <= SS; i++) begin
        ha[i] = 1; hb[i] = 0; hc[i] = 1;
      end
      m_q = 0; m_cnt = 0;
    end else begin
      int ca, pa, cb, pb, cc, pc;
      bit go;
      ca = ha[SS-1]; pa = ha[SS];
      cb = hb[SS-1]; pb = hb[SS];
      cc = hc[SS-1]; pc = hc[SS];
      go = (cc == 1) && ((pa == 1 && ca == 0 && cb == 1) ||
                         (pb == 0 && cb == 1 && ca == 0) ||
                         (pc == 0 && cc == 1 && ca == 0 && cb == 1));
      if (cc == 0) begin
        m_q = 0; m_cnt = 0;
      end else if (m_q) begin
        m_cnt = m_cnt - 1;
        if (m_cnt <= 0) begin
          m_q = 0; m_cnt = 0;
        end
      end else if (go) begin
        m_q = 1;
        m_cnt = (width == 0) ? 1 : int'(width);
      end
      for (int i = SS; i > 0; i--) begin
        ha[i] = ha[i-1]; hb[i] = hb[i-1]; hc[i] = hc[i-1];
      end
      ha[0] = int'(fall_n); hb[0] = int'(rise); hc[0] = int'(clr_n);
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      chk(pulse === m_q, cur_req, int'(pulse), int'(m_q));
      chk(pulse_n === ~pulse, "R12", int'(pulse_n), int'(~pulse));
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // act: 0 none, 1 change width, 2 drop clear, 3 toggle rise for 8 cycles
  task automatic pulse_meas(input int act_at, input int act, output int lat, output int len);
    lat = 0;
    while (!pulse && lat < 100) begin
      @(negedge clk); lat++;
    end
    len = 0;
    while (pulse && len < 300) begin
      if (act == 1 && len == act_at) width = 2;
      if (act == 2 && len == act_at) clr_n = 1'b0;
      if (act == 3 && len >= act_at && len < act_at + 8) rise = ~rise;
      @(negedge clk); len++;
    end
  endtask

  task automatic expect_quiet(input int n, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pulse) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int lat, len;
    arst_n = 1'b0; fall_n = 1'b1; rise = 1'b0; clr_n = 1'b1; width = 5;
    wait_n(3);
    chk(pulse == 1'b0, "R1", int'(pulse), 0);
    chk(pulse_n == 1'b1, "R1", int'(pulse_n), 1);
    arst_n = 1'b1;
    wait_n(6);
    chk(pulse == 1'b0 && pulse_n == 1'b1, "R1", int'(pulse), 0);
    mon_en = 1'b1;

    // R2 / R6: falling trigger gated by rise high
    cur_req = "R2";
    rise = 1'b1; wait_n(4);
    fall_n = 1'b0;
    pulse_meas(0, 0, lat, len);
    chk(lat == LAT, "R2", lat, LAT);
    chk(len == 5, "R6", len, 5);
    wait_n(5); fall_n = 1'b1; wait_n(5);

    // R5: edges without enabling level
    cur_req = "R5";
    rise = 1'b0; wait_n(4);
    fall_n = 1'b0;
    expect_quiet(8, "R5");
    fall_n = 1'b1; wait_n(4);
    rise = 1'b1;
    expect_quiet(8, "R5");
    rise = 1'b0; wait_n(4);
    fall_n = 1'b0;
    expect_quiet(6, "R5");

    // R3 / R6: rising trigger, width changed mid-pulse
    cur_req = "R3";
    width = 7;
    rise = 1'b1;
    pulse_meas(4, 1, lat, len);
    chk(lat == LAT, "R3", lat, LAT);
    chk(len == 7, "R6", len, 7);
    wait_n(6);

    // R10: clear held low inhibits, then R4: release triggers
    cur_req = "R10";
    clr_n = 1'b0; wait_n(4);
    rise = 1'b0; wait_n(3);
    rise = 1'b1; wait_n(3);
    fall_n = 1'b1; wait_n(3);
    fall_n = 1'b0;
    expect_quiet(6, "R10");
    cur_req = "R4";
    width = 4;
    clr_n = 1'b1;
    pulse_meas(0, 0, lat, len);
    chk(lat == LAT, "R4", lat, LAT);
    chk(len == 4, "R4", len, 4);
    wait_n(6);

    // R7: zero width
    cur_req = "R7";
    width = 0;
    rise = 1'b0; wait_n(4);
    rise = 1'b1;
    pulse_meas(0, 0, lat, len);
    chk(len == 1, "R7", len, 1);
    wait_n(6);

    // R6: maximum width
    cur_req = "R6";
    width = 6'h3f;
    rise = 1'b0; wait_n(4);
    rise = 1'b1;
    pulse_meas(0, 0, lat, len);
    chk(len == 63, "R6", len, 63);
    wait_n(6);

    // R8: retrigger attempts during pulse
    cur_req = "R8";
    width = 20;
    rise = 1'b0; wait_n(4);
    rise = 1'b1;
    pulse_meas(3, 3, lat, len);
    chk(len == 20, "R8", len, 20);
    expect_quiet(10, "R8");

    // R9: truncation by clear
    cur_req = "R9";
    width = 30;
    rise = 1'b0; wait_n(4);
    rise = 1'b1;
    pulse_meas(5, 2, lat, len);
    chk(len == 5 + LAT, "R9", len, 5 + LAT);
    rise = 1'b0; wait_n(4);
    clr_n = 1'b1;
    expect_quiet(8, "R10");

    // R11: clear release coincident with rising trigger
    cur_req = "R11";
    width = 6;
    clr_n = 1'b0; wait_n(4);
    clr_n = 1'b1; rise = 1'b1;
    pulse_meas(0, 0, lat, len);
    chk(len == 6, "R11", len, 6);
    expect_quiet(15, "R11");

    wait_n(5);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule